// File: doc/BRIEF.md
# PCM Highway Time-Slot Port

This block connects a telephony device to a shared PCM highway. It runs on the highway bit clock and watches the frame sync. It places one outgoing voice sample and takes one incoming voice sample per frame, each at its own programmable clock offset from the frame sync. Several devices can therefore share one transmit wire and one receive wire, each using its own time slot. The serial data pad is released outside the block's own transmit slot. The pad itself sits outside the block, which supplies the data and the enable for it.

A sample is either one 8-bit companded code (µ-law or A-law) or one 16-bit linear word, and it always travels MSB first. The block does not compand; the code is carried as it is. The host loads the outgoing sample into a parallel input. That sample is captured at the frame sync, so the host may change it during a frame. The incoming sample is placed in a parallel holding output, and a single-cycle valid strobe marks its arrival. A double-clocked mode holds each data bit for two clock cycles. In that mode, an early-release option frees the pad halfway through the last bit.

Top module: `pcm_slot_port`

## Requirements
- R1: During and after reset, and until the first frame sync has been seen, `dtx_en_o`, `dtx_o`, `rx_valid_o` and `rx_data_o` are all 0.
- R2: Clock edges are numbered from the edge at which `fsync_i` is first sampled high, which is edge 0. An FSYNC held high for several cycles does not restart the count.
- R3: The first transmit bit and `dtx_en_o` = 1 appear right after edge `tx_start_i`. A start count of 0 is valid.
- R4: Transmission is MSB first. For `fmt_i` = 0 (µ-law), 1 (A-law) and 3, the block sends `tx_data_i[7:0]` (8 bits). For `fmt_i` = 2 (linear), it sends all of `tx_data_i[15:0]` (16 bits).
- R5: When `dbl_clk_i` = 1, each transmit bit is held for 2 clock cycles and each receive bit spans 2 cycles. When `dbl_clk_i` = 0, each bit lasts 1 cycle.
- R6: `dtx_en_o` is 0 outside the slot, and `dtx_o` reads 0 whenever `dtx_en_o` is 0. With N bits per sample and B cycles per bit, the enable falls at edge `tx_start_i`+N·B. When `early_rel_i` = 1 and `dbl_clk_i` = 1, it falls one edge earlier. When `dbl_clk_i` = 0, `early_rel_i` has no effect.
- R7: Receive bit i (i = 0 is the MSB) is sampled from `drx_i` at edge `rx_start_i`+(i+1)·B. Levels outside these edges are ignored.
- R8: After the last receive bit, `rx_data_o` takes the assembled sample and `rx_valid_o` is high for exactly one cycle. An 8-bit sample sits in bits [7:0], and bits [15:8] are 0. `rx_data_o` holds its value at all other times.
- R9: The transmit sample is captured at edge 0. Changes to `tx_data_i` after that edge do not alter the sample sent in the current frame.
- R10: Start counts are 10 bits wide. Offsets up to 1023 place the transmit and receive slots correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Highway bit clock; all sampling and launching on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | Frame sync, short or long pulse |
| drx_i | input | 1 | Serial receive data from the highway |
| dtx_o | output | 1 | Serial transmit data toward the pad |
| dtx_en_o | output | 1 | Pad drive enable; 0 means high impedance |
| fmt_i | input | 2 | Sample format: 0 µ-law, 1 A-law, 2 linear 16-bit, 3 treated as 8-bit |
| dbl_clk_i | input | 1 | Double-clocked mode, two clock cycles per bit |
| early_rel_i | input | 1 | Release the pad halfway through the last bit (double-clocked only) |
| tx_start_i | input | 10 | Transmit slot offset in clock cycles after the frame sync |
| rx_start_i | input | 10 | Receive slot offset in clock cycles after the frame sync |
| tx_data_i | input | 16 | Sample to transmit |
| rx_data_o | output | 16 | Last received sample |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_data_o` updates |

## Verification
The bench builds the block with its defaults: 10-bit offsets and a 16-bit sample register. At these values both the zero offset and the far end of the offset range, 1000 and 1023 cycles after the sync, can be reached in frames of about a thousand cycles. Each frame is checked edge by edge against a schedule derived from the offsets, the format and the clocking mode. The schedule covers the enable window, the bit sent at every edge, and the edge at which the received sample is due. The 16-bit setting lets linear frames and the one-cycle-early release be checked at full length.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int SAMPLE_W = 16;
  localparam int HALF_W   = SAMPLE_W / 2;

  typedef enum logic [1:0] {
    FMT_ULAW  = 2'd0,
    FMT_ALAW  = 2'd1,
    FMT_LIN16 = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_e;

  function automatic logic is_wide(fmt_e f);
    return f == FMT_LIN16;
  endfunction
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
  parameter int POS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  output logic             frame_start_o,
  output logic [POS_W-1:0] pos_o,
  output logic             pos_vld_o
);
  logic             fs_q;
  logic             synced_q;
  logic [POS_W-1:0] cnt_q;

  assign frame_start_o = fsync_i & ~fs_q;
  assign pos_o         = frame_start_o ? '0 : cnt_q;
  assign pos_vld_o     = frame_start_o | synced_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q     <= 1'b0;
      synced_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      fs_q <= fsync_i;
      if (frame_start_o) begin
        cnt_q    <= POS_W'(1);
        synced_q <= 1'b1;
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + POS_W'(1);  // saturate so no slot re-fires late in a long frame
      end
    end
  end

  AST_SYNC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    synced_q |=> synced_q);  // R2
  AST_POS_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> (pos_o == POS_W'(1)));  // R2
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
  parameter int CNT_W    = 10,
  parameter int POS_W    = CNT_W + 1,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_start_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic                pos_vld_i,
  input  logic [CNT_W-1:0]    start_i,
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic                wide_i,
  input  logic                dbl_i,
  input  logic                early_i,
  output logic                dtx_o,
  output logic                dtx_en_o
);
  localparam int HALF_W = SAMPLE_W / 2;
  localparam int BIT_W  = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] hold_q, sh_q, src, load;
  logic [BIT_W-1:0]    left_q;
  logic                busy_q, ph_q, en_q;
  logic                start_hit, last_ph;

  assign start_hit = pos_vld_i && (pos_i == POS_W'(start_i));
  assign src       = frame_start_i ? data_i : hold_q;
  assign load      = wide_i ? src : {src[HALF_W-1:0], {HALF_W{1'b0}}};
  assign last_ph   = ~dbl_i | ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (frame_start_i) hold_q <= data_i;
      if (start_hit) begin
        busy_q <= 1'b1;
        sh_q   <= load;
        left_q <= wide_i ? BIT_W'(SAMPLE_W-1) : BIT_W'(HALF_W-1);
        ph_q   <= 1'b0;
        en_q   <= 1'b1;
      end else if (busy_q) begin
        if (last_ph) begin
          if (left_q == '0) begin
            busy_q <= 1'b0;
            en_q   <= 1'b0;
          end else begin
            sh_q   <= sh_q << 1;
            left_q <= left_q - BIT_W'(1);
            ph_q   <= 1'b0;
          end
        end else begin
          ph_q <= 1'b1;
          if (early_i && left_q == '0) en_q <= 1'b0;  // release mid last bit
        end
      end
    end
  end

  assign dtx_o    = en_q & sh_q[SAMPLE_W-1];
  assign dtx_en_o = en_q;

  AST_TX_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_hit |=> dtx_en_o);  // R3
  AST_TX_DBL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbl_i && busy_q && !ph_q && !start_hit) |=> $stable(sh_q));  // R5
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int CNT_W    = 10,
  parameter int POS_W    = CNT_W + 1,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [POS_W-1:0]    pos_i,
  input  logic                pos_vld_i,
  input  logic [CNT_W-1:0]    start_i,
  input  logic                wide_i,
  input  logic                dbl_i,
  input  logic                drx_i,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                valid_o
);
  localparam int HALF_W = SAMPLE_W / 2;
  localparam int BIT_W  = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] sh_q, data_q;
  logic [BIT_W-1:0]    got_q, last_idx;
  logic                busy_q, ph_q, vld_q;
  logic                start_hit, last_ph;

  assign start_hit = pos_vld_i && (pos_i == POS_W'(start_i));
  assign last_ph   = ~dbl_i | ph_q;
  assign last_idx  = wide_i ? BIT_W'(SAMPLE_W-1) : BIT_W'(HALF_W-1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      data_q <= '0;
      got_q  <= '0;
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (start_hit) begin
        busy_q <= 1'b1;
        ph_q   <= 1'b0;
        got_q  <= '0;
      end else if (busy_q) begin
        if (last_ph) begin
          sh_q <= {sh_q[SAMPLE_W-2:0], drx_i};
          ph_q <= 1'b0;
          if (got_q == last_idx) begin
            busy_q <= 1'b0;
            vld_q  <= 1'b1;
            data_q <= wide_i ? {sh_q[SAMPLE_W-2:0], drx_i}
                             : {{HALF_W{1'b0}}, sh_q[HALF_W-2:0], drx_i};
          end else begin
            got_q <= got_q + BIT_W'(1);
          end
        end else begin
          ph_q <= 1'b1;
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = vld_q;

  AST_RX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);  // R8
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));  // R8
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int CNT_W = 10
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               fsync_i,
  input  logic                               drx_i,
  output logic                               dtx_o,
  output logic                               dtx_en_o,
  input  logic [1:0]                         fmt_i,
  input  logic                               dbl_clk_i,
  input  logic                               early_rel_i,
  input  logic [CNT_W-1:0]                   tx_start_i,
  input  logic [CNT_W-1:0]                   rx_start_i,
  input  logic [pcm_slot_pkg::SAMPLE_W-1:0]  tx_data_i,
  output logic [pcm_slot_pkg::SAMPLE_W-1:0]  rx_data_o,
  output logic                               rx_valid_o
);
  import pcm_slot_pkg::*;

  localparam int POS_W = CNT_W + 1;

  logic             frame_start, pos_vld, wide;
  logic [POS_W-1:0] pos;

  assign wide = is_wide(fmt_e'(fmt_i));

  pcm_frame_timer #(.POS_W(POS_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fsync_i      (fsync_i),
    .frame_start_o(frame_start),
    .pos_o        (pos),
    .pos_vld_o    (pos_vld)
  );

  pcm_tx_slot #(.CNT_W(CNT_W), .POS_W(POS_W), .SAMPLE_W(SAMPLE_W)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start),
    .pos_i        (pos),
    .pos_vld_i    (pos_vld),
    .start_i      (tx_start_i),
    .data_i       (tx_data_i),
    .wide_i       (wide),
    .dbl_i        (dbl_clk_i),
    .early_i      (early_rel_i),
    .dtx_o        (dtx_o),
    .dtx_en_o     (dtx_en_o)
  );

  pcm_rx_slot #(.CNT_W(CNT_W), .POS_W(POS_W), .SAMPLE_W(SAMPLE_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pos_i    (pos),
    .pos_vld_i(pos_vld),
    .start_i  (rx_start_i),
    .wide_i   (wide),
    .dbl_i    (dbl_clk_i),
    .drx_i    (drx_i),
    .data_o   (rx_data_o),
    .valid_o  (rx_valid_o)
  );

  AST_TX_NEEDS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dtx_en_o |-> pos_vld);  // R1
  AST_RX_NEEDS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> pos_vld);  // R1
  AST_DTX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dtx_en_o |-> !dtx_o);  // R6
endmodule

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0, drx = 1'b0;
  logic        dtx, dtx_en;
  logic [1:0]  fmt_sel = 2'd0;
  logic        dbl_clk = 1'b0, early_rel = 1'b0;
  logic [9:0]  tx_start = '0, rx_start = '0;
  logic [15:0] tx_data = '0, rx_data;
  logic        rx_valid;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_slot_port uut (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .drx_i(drx),
    .dtx_o(dtx), .dtx_en_o(dtx_en), .fmt_i(fmt_sel), .dbl_clk_i(dbl_clk),
    .early_rel_i(early_rel), .tx_start_i(tx_start), .rx_start_i(rx_start),
    .tx_data_i(tx_data), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic run_frame(string tag, int s, int r, logic [1:0] fmt, bit dbl, bit early,
                           logic [15:0] txv, logic [15:0] rxv, int fs_len, bit mutate);
    int n    = (fmt == 2'd2) ? 16 : 8;
    int bpc  = dbl ? 2 : 1;
    int adj  = (early && dbl) ? 1 : 0;
    int last = ((s > r) ? s : r) + n * bpc + 3;
    logic [15:0] rx_exp = (n == 16) ? rxv : {8'h00, rxv[7:0]};
    logic exp_en;
    @(negedge clk);
    tx_start = 10'(s); rx_start = 10'(r); fmt_sel = fmt; dbl_clk = dbl;
    early_rel = early; tx_data = txv; fsync = 1'b1; drx = 1'b1;
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      exp_en = (k >= s) && (k < s + n * bpc - adj);
      chk(tag, "dtx_en", {15'd0, dtx_en}, {15'd0, exp_en});
      if (exp_en) chk(tag, "dtx bit", {15'd0, dtx}, {15'd0, txv[n - 1 - (k - s) / bpc]});
      else        chk(tag, "dtx idle", {15'd0, dtx}, 16'd0);
      chk(tag, "rx_valid", {15'd0, rx_valid}, {15'd0, k == r + n * bpc});
      if (k == r + n * bpc) chk(tag, "rx_data", rx_data, rx_exp);
      if (k + 1 >= fs_len) fsync = 1'b0;
      if (mutate && k == 0) tx_data = ~txv;
      if (k >= r && (k - r) / bpc < n) drx = rxv[n - 1 - (k - r) / bpc];
      else drx = ~drx;  // noise outside the window must be ignored
    end
    fsync = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "en in reset", {15'd0, dtx_en}, 16'd0);
    chk("R1", "rx_data in reset", rx_data, 16'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      drx = ~drx;
      @(negedge clk);
      chk("R1", "en before sync", {15'd0, dtx_en}, 16'd0);
      chk("R1", "dtx before sync", {15'd0, dtx}, 16'd0);
      chk("R1", "valid before sync", {15'd0, rx_valid}, 16'd0);
    end
  endtask

  task automatic t_ulaw();      run_frame("R3_R7_R8", 3, 5, 2'd0, 0, 0, 16'hFFA5, 16'h003C, 1, 0); endtask
  task automatic t_alaw_zero(); run_frame("R3", 0, 0, 2'd1, 0, 0, 16'h00D2, 16'h0081, 1, 0); endtask
  task automatic t_linear();    run_frame("R4_R8", 10, 2, 2'd2, 0, 0, 16'hB38E, 16'h9C71, 1, 0); endtask
  task automatic t_fmt3();      run_frame("R4", 1, 4, 2'd3, 0, 0, 16'h5A6B, 16'hE74F, 1, 0); endtask
  task automatic t_double();    run_frame("R5", 4, 4, 2'd0, 1, 0, 16'h0093, 16'h00C6, 1, 0); endtask
  task automatic t_early_dbl(); run_frame("R6", 2, 7, 2'd2, 1, 1, 16'hC0F5, 16'h1E2D, 1, 0); endtask
  task automatic t_early_sgl(); run_frame("R6", 6, 3, 2'd1, 0, 1, 16'h0071, 16'h00AE, 1, 0); endtask
  task automatic t_long_fs();   run_frame("R2", 2, 3, 2'd0, 0, 0, 16'h00E1, 16'h0056, 6, 0); endtask
  task automatic t_latch();     run_frame("R9", 5, 5, 2'd2, 0, 0, 16'h69A3, 16'h2B4C, 1, 1); endtask
  task automatic t_wide();      run_frame("R10", 1000, 1023, 2'd0, 0, 0, 16'h004D, 16'h00B2, 1, 0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog act=hung exp=complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ulaw();
    t_alaw_zero();
    t_linear();
    t_fmt3();
    t_double();
    t_early_dbl();
    t_early_sgl();
    t_long_fs();
    t_latch();
    t_wide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule